// File: doc/BRIEF.md
# Zero-Run Automute and Soft-Mute Gain Stage

This block sits on a parallel stereo sample stream, one left and one right signed sample per strobe, and scales both channels by a shared gain. The gain is a 9-bit value from 0 (silence) to 256 (unity). It moves one step per sample toward its target, so muting and unmuting fade the audio over 256 sample periods, about 5 ms at 48 kHz, instead of cutting it abruptly.

The mute request has three states, carried on two inputs. A drive-enable says whether the request is being driven, and a level input gives its value. Driven low requests mute. Driven high forces normal operation. When the request is not driven, an internal detector decides instead. The detector counts consecutive sample periods in which both channels are exactly zero. After 1024 such periods it sets a latched automuted flag, which then requests mute. The first non-zero sample on either channel clears the flag. The flag is also brought out so that circuits outside the block can act on it.

Top module: `automute_softmute`

## Requirements
- R1: After reset, gain_o is 256, automuted_o is 0, out_valid_o is 0 and both output samples are 0.
- R2: With the request driven high (mute_drive_i=1, mute_level_i=1) and the gain at 256, each output sample equals its input sample. out_valid_o is high in the cycle after each sample_valid_i strobe.
- R3: While mute is requested, gain_o drops by exactly 1 at each strobe until it reaches 0, and then stays at 0. An output produced with gain 0 is 0.
- R4: While mute is not requested, gain_o rises by exactly 1 at each strobe until it reaches 256, and then stays at 256.
- R5: Each output sample is input × gain / 256, rounded toward zero. The gain used is the value gain_o held before that strobe's update.
- R6: automuted_o becomes 1 in the cycle after the 1024th consecutive strobe in which both channels are zero. After 1023 such strobes it is still 0.
- R7: A strobe with a non-zero sample on either channel clears automuted_o at once and restarts the zero run from 0. Further zero strobes after the flag is set keep it set, because the counter saturates.
- R8: With the request not driven (mute_drive_i=0), automuted_o acts as the mute request: 1 means mute and 0 means no mute.
- R9: Driving the request high overrides automuted_o, so the gain does not fall while the flag is set. Driving it low mutes whatever the flag holds.
- R10: Without a strobe, gain_o, automuted_o and the outputs do not change, and out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe: one stereo sample this cycle |
| left_i | input | DATA_W | Left input sample, two's complement |
| right_i | input | DATA_W | Right input sample, two's complement |
| mute_drive_i | input | 1 | 1 = mute request is driven, 0 = not driven (zero detector decides) |
| mute_level_i | input | 1 | Level of the driven request: 0 = mute, 1 = normal |
| left_o | output | DATA_W | Left output sample after gain |
| right_o | output | DATA_W | Right output sample after gain |
| out_valid_o | output | 1 | Output samples updated this cycle |
| gain_o | output | GAIN_FRAC+1 | Current gain, 0..2^GAIN_FRAC |
| automuted_o | output | 1 | Zero-run detector latch |

## Verification
Random signed samples at unity gain show whether the data path is transparent. The same samples during partial ramps, including small negative values, separate truncation toward zero from floor rounding, and catch use of the wrong gain value (before versus after the update). Runs of zeros are stopped at exactly 1023 and at 1024 to pin down the detector threshold. A single non-zero sample placed inside a run shows that the counter restarts rather than carrying on. The same zero runs are repeated with the request floating, driven high and driven low, to tell apart the three sources of the mute request.

// File: rtl/automute_pkg.sv
package automute_pkg;
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_FORCE = 2'd1,
    REQ_AUTO  = 2'd2
  } req_src_e;
endpackage

// File: rtl/am_zero_detect.sv
module am_zero_detect #(
  parameter int DATA_W   = 24,
  parameter int ZERO_RUN = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              flag_o
);
  localparam int CNT_W = $clog2(ZERO_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ZERO_RUN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ZERO_RUN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             both_zero;

  assign both_zero = (left_i == '0) && (right_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (valid_i) begin
      if (both_zero) begin
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;  // saturate
        if (cnt_q == CNT_LAST) flag_q <= 1'b1;
      end else begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end
    end
  end

  assign flag_o = flag_q;

  a_r6_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && both_zero && cnt_q == CNT_LAST |=> flag_q);
  a_r6_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |-> cnt_q == CNT_MAX);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !both_zero |=> !flag_q && cnt_q == '0);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && valid_i && both_zero |=> flag_q);
endmodule

// File: rtl/am_gain_ramp.sv
module am_gain_ramp #(
  parameter int GAIN_FRAC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               mute_req_i,
  output logic [GAIN_FRAC:0] gain_o
);
  localparam int GW = GAIN_FRAC + 1;
  localparam logic [GW-1:0] UNITY = GW'(1 << GAIN_FRAC);

  logic [GW-1:0] gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= UNITY;
    end else if (valid_i) begin
      if (mute_req_i) begin
        if (gain_q != '0) gain_q <= gain_q - 1'b1;
      end else if (gain_q != UNITY) begin
        gain_q <= gain_q + 1'b1;
      end
    end
  end

  assign gain_o = gain_q;

  a_r3_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mute_req_i && gain_q != '0 |=> gain_q == $past(gain_q) - 1'b1);
  a_r4_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mute_req_i && gain_q != UNITY |=> gain_q == $past(gain_q) + 1'b1);
  a_r4_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_q <= UNITY);
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(gain_q));
endmodule

// File: rtl/am_gain_apply.sv
module am_gain_apply #(
  parameter int DATA_W    = 24,
  parameter int GAIN_FRAC = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic [GAIN_FRAC:0] gain_i,
  output logic [DATA_W-1:0]  data_o
);
  localparam int GW = GAIN_FRAC + 1;
  localparam int PW = DATA_W + GW + 1;
  localparam logic signed [PW-1:0] DIVISOR = PW'(1 << GAIN_FRAC);

  logic signed [PW-1:0] d_ext, g_ext, prod, quot;
  logic [DATA_W-1:0]    data_q;

  assign d_ext = {{(PW-DATA_W){data_i[DATA_W-1]}}, data_i};
  assign g_ext = {{(PW-GW){1'b0}}, gain_i};
  assign prod  = d_ext * g_ext;
  assign quot  = prod / DIVISOR;  // signed division truncates toward zero

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (valid_i) data_q <= DATA_W'(quot);
  end

  assign data_o = data_q;

  a_r3_zero_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && gain_i == '0 |=> data_q == '0);
  a_r2_unity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && gain_i == GW'(1 << GAIN_FRAC) |=> data_q == $past(data_i));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_q));
endmodule

// File: rtl/automute_softmute.sv
module automute_softmute
  import automute_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int GAIN_FRAC = 8,
  parameter int ZERO_RUN  = 1024
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_valid_i,
  input  logic [DATA_W-1:0]  left_i,
  input  logic [DATA_W-1:0]  right_i,
  input  logic               mute_drive_i,
  input  logic               mute_level_i,
  output logic [DATA_W-1:0]  left_o,
  output logic [DATA_W-1:0]  right_o,
  output logic               out_valid_o,
  output logic [GAIN_FRAC:0] gain_o,
  output logic               automuted_o
);
  localparam int NCH = 2;

  req_src_e                src;
  logic                    mute_req, auto_flag, vld_q;
  logic [GAIN_FRAC:0]      gain;
  logic [NCH-1:0][DATA_W-1:0] ch_in, ch_out;

  am_zero_detect #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) u_zero (
    .clk_i, .rst_ni, .valid_i(sample_valid_i),
    .left_i, .right_i, .flag_o(auto_flag)
  );

  // Driven request wins; floating request defers to the zero detector.
  always_comb begin
    if (mute_drive_i) src = mute_level_i ? REQ_NONE : REQ_FORCE;
    else              src = auto_flag ? REQ_AUTO : REQ_NONE;
    mute_req = (src != REQ_NONE);
  end

  am_gain_ramp #(.GAIN_FRAC(GAIN_FRAC)) u_ramp (
    .clk_i, .rst_ni, .valid_i(sample_valid_i),
    .mute_req_i(mute_req), .gain_o(gain)
  );

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    am_gain_apply #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC)) u_apply (
      .clk_i, .rst_ni, .valid_i(sample_valid_i),
      .data_i(ch_in[c]), .gain_i(gain), .data_o(ch_out[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= sample_valid_i;
  end

  assign left_o      = ch_out[0];
  assign right_o     = ch_out[1];
  assign out_valid_o = vld_q;
  assign gain_o      = gain;
  assign automuted_o = auto_flag;

  a_r8_auto_mutes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i && !mute_drive_i && auto_flag && gain != '0
    |=> gain_o == $past(gain) - 1'b1);
  a_r9_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i && mute_drive_i && mute_level_i |=> gain_o >= $past(gain));
  a_r9_force: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i && mute_drive_i && !mute_level_i |=> gain_o <= $past(gain));
  a_r2_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> out_valid_o);
endmodule

// File: tb/automute_softmute_test.sv
`timescale 1ns/1ps
module automute_softmute_test;
  localparam int DW = 24;
  localparam int UNITY = 256;
  localparam int RUN = 1024;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vld = 1'b0, drv = 1'b1, lvl = 1'b1;
  logic [DW-1:0] l_in = '0, r_in = '0;
  logic [DW-1:0] l_out, r_out;
  logic ov, am;
  logic [8:0] g_out;

  int errors = 0, checks = 0;
  int m_gain = UNITY, m_cnt = 0;
  bit m_am = 0;

  always #10 clk = ~clk;

  automute_softmute uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(vld),
    .left_i(l_in), .right_i(r_in), .mute_drive_i(drv), .mute_level_i(lvl),
    .left_o(l_out), .right_o(r_out), .out_valid_o(ov),
    .gain_o(g_out), .automuted_o(am)
  );

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, got running expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] x, input int g);
    longint p, q;
    p = longint'($signed(x)) * g;
    if (p < 0) q = -((-p) >> 8);
    else       q = p >> 8;
    return DW'(q);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One sample strobe; check all outputs one cycle later.
  task automatic send(input string tag, input logic [DW-1:0] l, input logic [DW-1:0] r,
                      input bit d, input bit v);
    bit req;
    logic [DW-1:0] el, er;
    @(negedge clk);
    vld = 1'b1; l_in = l; r_in = r; drv = d; lvl = v;
    req = d ? !v : m_am;
    el = scale(l, m_gain);
    er = scale(r, m_gain);
    if (req) begin if (m_gain > 0) m_gain--; end
    else if (m_gain < UNITY) m_gain++;
    if (l == '0 && r == '0) begin
      if (m_cnt < RUN) m_cnt++;
      if (m_cnt == RUN) m_am = 1;
    end else begin
      m_cnt = 0; m_am = 0;
    end
    @(negedge clk);
    vld = 1'b0;
    chk({tag, " left"}, l_out, el);
    chk({tag, " right"}, r_out, er);
    chk({tag, " gain"}, g_out, m_gain);
    chk({tag, " flag"}, am, m_am);
    chk({tag, " valid"}, ov, 1);
  endtask

  task automatic idle_check(input int n);
    logic [8:0] g0; logic [DW-1:0] l0;
    g0 = g_out; l0 = l_out;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b0; l_in = DW'($urandom); r_in = DW'($urandom);
    end
    chk("R10 idle gain", g_out, g0);
    chk("R10 idle data", l_out, l0);
    chk("R10 idle valid", ov, 0);
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  initial begin
    void'($urandom(32'h5eed_0729));
    repeat (3) @(negedge clk);
    chk("R1 reset gain", g_out, UNITY);
    chk("R1 reset flag", am, 0);
    chk("R1 reset valid", ov, 0);
    chk("R1 reset data", l_out, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 40; i++) send("R2 unity", rnd(), rnd(), 1, 1);
    idle_check(5);

    for (int i = 0; i < 300; i++) send("R3 forced mute", rnd(), rnd(), 1, 0);
    chk("R3 gain floor", g_out, 0);
    chk("R3 silent", l_out, 0);

    for (int i = 0; i < 100; i++) send("R4 partial up", rnd(), rnd(), 1, 1);
    for (int i = 0; i < 20; i++)
      send("R5 small negative", DW'(-(i + 1)), DW'(-(3 * i + 1)), 1, 1);
    for (int i = 0; i < 50; i++) send("R3 partial down", rnd(), rnd(), 1, 0);
    send("R5 minus one", DW'(-1), DW'(-255), 1, 0);
    for (int i = 0; i < 300; i++) send("R4 ramp up", rnd(), rnd(), 1, 1);
    chk("R4 gain ceiling", g_out, UNITY);

    for (int i = 0; i < RUN - 1; i++) send("R6 zero run", '0, '0, 0, 0);
    chk("R6 not yet at 1023", am, 0);
    send("R6 zero run last", '0, '0, 0, 0);
    chk("R6 set at 1024", am, 1);
    for (int i = 0; i < 300; i++) send("R8 auto mute", '0, '0, 0, 1);
    chk("R8 gain reached 0", g_out, 0);
    chk("R7 saturated flag", am, 1);
    idle_check(4);

    send("R7 right nonzero", '0, DW'(5), 0, 0);
    chk("R7 cleared", am, 0);
    for (int i = 0; i < 300; i++) send("R4 auto release", rnd(), rnd(), 0, 0);

    for (int i = 0; i < 600; i++) send("R7 run a", '0, '0, 0, 0);
    send("R7 break", DW'(1), '0, 0, 0);
    for (int i = 0; i < 600; i++) send("R7 run b", '0, '0, 0, 0);
    chk("R7 restart no flag", am, 0);
    for (int i = 0; i < RUN - 600; i++) send("R6 run b rest", '0, '0, 0, 0);
    chk("R6 set after restart", am, 1);

    for (int i = 0; i < 100; i++) send("R9 override", '0, '0, 1, 1);
    chk("R9 gain held", g_out, UNITY);
    chk("R9 flag still set", am, 1);
    for (int i = 0; i < 10; i++) send("R9 driven low", '0, '0, 1, 0);
    chk("R9 forced mute", g_out, UNITY - 10);

    for (int i = 0; i < 400; i++) begin
      bit d = 1'($urandom);
      send("R5 mixed random", ($urandom % 4 == 0) ? '0 : rnd(), rnd(), d, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule